// File: doc/BRIEF.md
# Defect-Aware Cache Access Steering

This unit sits ahead of a second-level cache whose subblocks have known manufacturing defects. For every access address it picks a route. Subblocks with no defect or one defect go down the normal path. Subblocks with exactly two defects go through a slow multi-bit error-correcting path. Subblocks with three or more defects are repaired by redundancy elsewhere and never come here. The set of two-defect subblock addresses is held in a small content-addressable table. That table is written only while the `init` input is high, from the results of memory test.

Two small LRU buffers keep the slow path idle.

- The address filter remembers recent addresses that proved not to be multi-defect. A repeat access to one of them goes straight to the normal path with no table search.
- The decoded-copy buffer keeps corrected data for recently read multi-defect subblocks. A repeat read of one of them is answered from the buffer, and the correction path is not started.

The correction engine returns corrected data through the fill port, and that data is installed in the decoded-copy buffer. Writes to a multi-defect subblock go through the correction path and drop any stale decoded copy.

The data arrays, the codec itself and redundancy repair are outside this unit.

Top module: `dcache_steer`

## Requirements
- R1: After reset, `resp_valid` and `ecc_start` are low. Both buffers are empty, so the first access to any address is not filtered.
- R2: An access offered while `init` is low gets exactly one response, with `resp_valid` high on the clock edge after it is offered. An access offered while `init` is high gets no response.
- R3: A table write (`cfg_we`) stores `cfg_valid`/`cfg_addr` at slot `cfg_idx` only while `init` is high. A table write made while `init` is low has no effect: an access to that address is still routed normal.
- R4: An address absent from the filter and the table is routed normal (`resp_route`=0) with `resp_filtered`=0, and it is recorded in the filter. A later access to it is routed normal with `resp_filtered`=1, and no table search is made.
- R5: The filter holds 64 addresses with least-recently-used replacement. A filter hit counts as a use.
- R6: A read of a table address that has no decoded copy is routed to the correction path (`resp_route`=2). In the same cycle as the response, `ecc_start`=1, `ecc_write`=0 and `ecc_addr` equals the access address.
- R7: Fill data (`fill_valid`, `fill_addr`, `fill_data`) is installed in the decoded-copy buffer. A later read of that table address is routed from the buffer (`resp_route`=1) with `resp_data` equal to the filled data, and `ecc_start`=0.
- R8: A write to a table address is routed to the correction path with `ecc_start`=1 and `ecc_write`=1. It removes any decoded copy of that address, so the next read goes to the correction path again.
- R9: The decoded-copy buffer holds 64 subblocks with least-recently-used replacement. A read hit and a fill each count as a use.
- R10: While `init` is high, both buffers are emptied. The table contents are kept.
- R11: A fill whose address equals a write to a table address in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init | input | 1 | Test-time configuration window; blocks accesses and empties buffers |
| cfg_we | input | 1 | Table slot write strobe |
| cfg_idx | input | 4 | Table slot index |
| cfg_valid | input | 1 | Valid flag written into the slot |
| cfg_addr | input | 20 | Multi-defect subblock address written into the slot |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 20 | Access subblock address |
| fill_valid | input | 1 | Corrected data returned by the correction engine |
| fill_addr | input | 20 | Subblock address of the returned data |
| fill_data | input | 32 | Returned corrected data |
| resp_valid | output | 1 | Route decision valid |
| resp_route | output | 2 | 0 normal, 1 decoded-copy buffer, 2 correction path |
| resp_filtered | output | 1 | Normal route decided by the address filter without a table search |
| resp_data | output | 32 | Data from the decoded-copy buffer when `resp_route`=1 |
| ecc_start | output | 1 | Starts the correction path |
| ecc_write | output | 1 | The started correction operation is a write |
| ecc_addr | output | 20 | Subblock address for the correction path |

## Verification
The bench targets the recency boundary of each 64-entry buffer. It refreshes the oldest entry, then adds one more entry. A design that evicted by insertion order, or ignored the refresh, would drop the refreshed entry instead of the second-oldest one. It also drives a write and a fill to the same table address in one cycle. A design that let the fill land would later serve stale data from the buffer instead of going to the correction path. Finally, it checks that a table write outside the `init` window, and an access during it, leave no trace, and that raising `init` empties both buffers so that previously filtered or buffered addresses miss again.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    ROUTE_NORMAL = 2'd0,
    ROUTE_COPY   = 2'd1,
    ROUTE_ECC    = 2'd2
  } route_e;
endpackage

// File: rtl/dcs_defect_cam.sv
// Table of multi-defect subblock addresses, written by slot index.
module dcs_defect_cam #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [$clog2(DEPTH)-1:0] load_idx,
  input  logic                     load_valid,
  input  logic [ADDR_W-1:0]        load_addr,
  input  logic                     search_en,
  input  logic [ADDR_W-1:0]        search_addr,
  output logic                     match
);
  logic [DEPTH-1:0]  vld_q, vld_d, hit_vec;
  logic [ADDR_W-1:0] key_q [DEPTH];

  always_comb begin
    vld_d = vld_q;
    if (load_en) vld_d[load_idx] = load_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vld_q <= '0;
    else if (load_en) vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) key_q[load_idx] <= load_addr;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = vld_q[i] && (key_q[i] == search_addr);
  end

  assign match = search_en && (|hit_vec);
endmodule

// File: rtl/dcs_lru_age.sv
// True LRU by per-entry age rank; ages always form a permutation.
module dcs_lru_age #(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     touch_en,
  input  logic [$clog2(DEPTH)-1:0] touch_idx,
  output logic [$clog2(DEPTH)-1:0] victim_idx
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [IW-1:0] OLDEST = IW'(DEPTH - 1);

  logic [IW-1:0] age_q [DEPTH];
  logic [IW-1:0] age_d [DEPTH];

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      age_d[j] = age_q[j];
      if (IW'(j) == touch_idx)              age_d[j] = '0;
      else if (age_q[j] < age_q[touch_idx]) age_d[j] = age_q[j] + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age_q[i] <= IW'(i);
      else if (touch_en) age_q[i] <= age_d[i];
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int j = 0; j < DEPTH; j++)
      if (age_q[j] == OLDEST) victim_idx = IW'(j);
  end
endmodule

// File: rtl/dcs_lru_buf.sv
// Fully associative tag/data buffer with LRU replacement.
module dcs_lru_buf #(
  parameter int DEPTH  = 64,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  input  logic              touch_en,
  input  logic              inv_en,
  input  logic              ins_en,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [DATA_W-1:0] ins_data
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0]  vld_q, vld_d, look_vec, ins_vec;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [IW-1:0]     hit_idx, ins_hit_idx, free_idx, victim_idx, ins_idx, lru_idx;
  logic              ins_hit, any_free, lru_touch, ins_go;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign look_vec[i] = vld_q[i] && (tag_q[i] == look_tag);
    assign ins_vec[i]  = vld_q[i] && (tag_q[i] == ins_tag);
  end

  always_comb begin
    hit_idx     = '0;
    ins_hit_idx = '0;
    free_idx    = '0;
    any_free    = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (look_vec[i]) hit_idx     = IW'(i);
      if (ins_vec[i])  ins_hit_idx = IW'(i);
      if (!vld_q[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  assign hit      = |look_vec;
  assign ins_hit  = |ins_vec;
  assign hit_data = dat_q[hit_idx];
  assign ins_idx  = ins_hit ? ins_hit_idx : (any_free ? free_idx : victim_idx);
  assign ins_go   = ins_en && !clear;

  always_comb begin
    vld_d = vld_q;
    if (inv_en && hit) vld_d[hit_idx] = 1'b0;
    if (ins_en)        vld_d[ins_idx] = 1'b1;
    if (clear)         vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (ins_go) begin
      tag_q[ins_idx] <= ins_tag;
      dat_q[ins_idx] <= ins_data;
    end
  end

  assign lru_touch = !clear && (ins_en || (touch_en && hit));
  assign lru_idx   = ins_en ? ins_idx : hit_idx;

  dcs_lru_age #(.DEPTH(DEPTH)) u_age (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (lru_touch),
    .touch_idx  (lru_idx),
    .victim_idx (victim_idx)
  );
endmodule

// File: rtl/dcache_steer.sv
module dcache_steer
  import dcs_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 32,
  parameter int CAM_DEPTH = 16,
  parameter int AFB_DEPTH = 64,
  parameter int PDB_DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         init,
  input  logic                         cfg_we,
  input  logic [$clog2(CAM_DEPTH)-1:0] cfg_idx,
  input  logic                         cfg_valid,
  input  logic [ADDR_W-1:0]            cfg_addr,
  input  logic                         acc_valid,
  input  logic                         acc_write,
  input  logic [ADDR_W-1:0]            acc_addr,
  input  logic                         fill_valid,
  input  logic [ADDR_W-1:0]            fill_addr,
  input  logic [DATA_W-1:0]            fill_data,
  output logic                         resp_valid,
  output logic [1:0]                   resp_route,
  output logic                         resp_filtered,
  output logic [DATA_W-1:0]            resp_data,
  output logic                         ecc_start,
  output logic                         ecc_write,
  output logic [ADDR_W-1:0]            ecc_addr
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              acc_go, afb_hit, afb_filt, cam_hit, copy_hit, fill_drop;
  logic              afb_touch, afb_ins, copy_touch, copy_inv, copy_ins;
  logic [0:0]        afb_mark;
  logic [DATA_W-1:0] copy_data;

  assign acc_go = acc_valid && !init;

  dcs_defect_cam #(.DEPTH(CAM_DEPTH), .ADDR_W(ADDR_W)) u_cam (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load_en     (cfg_we && init),
    .load_idx    (cfg_idx),
    .load_valid  (cfg_valid),
    .load_addr   (cfg_addr),
    .search_en   (acc_go && !afb_filt),
    .search_addr (acc_addr),
    .match       (cam_hit)
  );

  dcs_lru_buf #(.DEPTH(AFB_DEPTH), .TAG_W(ADDR_W), .DATA_W(1)) u_afb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear    (init),
    .look_tag (acc_addr),
    .hit      (afb_hit),
    .hit_data (afb_mark),
    .touch_en (afb_touch),
    .inv_en   (1'b0),
    .ins_en   (afb_ins),
    .ins_tag  (acc_addr),
    .ins_data (1'b1)
  );

  assign afb_filt = afb_hit && afb_mark[0];

  dcs_lru_buf #(.DEPTH(PDB_DEPTH), .TAG_W(ADDR_W), .DATA_W(DATA_W)) u_copy (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear    (init),
    .look_tag (acc_addr),
    .hit      (copy_hit),
    .hit_data (copy_data),
    .touch_en (copy_touch),
    .inv_en   (copy_inv),
    .ins_en   (copy_ins),
    .ins_tag  (fill_addr),
    .ins_data (fill_data)
  );

  // route decision (next state)
  route_e            route_d, route_q;
  logic              filt_d, start_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    route_d    = ROUTE_NORMAL;
    filt_d     = 1'b0;
    start_d    = 1'b0;
    data_d     = resp_data;
    afb_touch  = 1'b0;
    afb_ins    = 1'b0;
    copy_touch = 1'b0;
    copy_inv   = 1'b0;
    if (acc_go) begin
      if (afb_filt) begin
        filt_d    = 1'b1;
        afb_touch = 1'b1;
      end else if (!cam_hit) begin
        afb_ins = 1'b1;
      end else if (!acc_write && copy_hit) begin
        route_d    = ROUTE_COPY;
        data_d     = copy_data;
        copy_touch = 1'b1;
      end else begin
        route_d  = ROUTE_ECC;
        start_d  = 1'b1;
        copy_inv = acc_write;
      end
    end
  end

  assign fill_drop = copy_inv && (fill_addr == acc_addr);
  assign copy_ins  = fill_valid && !init && !fill_drop;

  // response registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      resp_valid <= 1'b0;
      ecc_start  <= 1'b0;
    end else begin
      resp_valid <= acc_go;
      ecc_start  <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      route_q       <= ROUTE_NORMAL;
      resp_filtered <= 1'b0;
      resp_data     <= '0;
      ecc_write     <= 1'b0;
      ecc_addr      <= '0;
    end else if (acc_go) begin
      route_q       <= route_d;
      resp_filtered <= filt_d;
      resp_data     <= data_d;
      ecc_write     <= start_d && acc_write;
      ecc_addr      <= acc_addr;
    end
  end

  assign resp_route = route_q;
endmodule

// File: rtl/dcache_steer_chk.sv
module dcache_steer_chk
  import dcs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       init,
  input logic       acc_valid,
  input logic       acc_write,
  input logic       resp_valid,
  input logic [1:0] resp_route,
  input logic       resp_filtered,
  input logic       ecc_start,
  input logic       ecc_write
);
  a_r2_resp_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(acc_valid && !init));

  a_r2_quiet_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init) |-> !resp_valid);

  a_r4_filter_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_filtered) |-> (resp_route == ROUTE_NORMAL));

  a_r6_ecc_start_route: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_start |-> (resp_valid && resp_route == ROUTE_ECC));

  a_r7_copy_no_ecc: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_route == ROUTE_COPY) |-> !ecc_start);

  a_r8_write_never_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(acc_write)) |-> (resp_route != ROUTE_COPY));

  a_r8_ecc_write_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_start && ecc_write) |-> $past(acc_write));
endmodule

bind dcache_steer dcache_steer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .init          (init),
  .acc_valid     (acc_valid),
  .acc_write     (acc_write),
  .resp_valid    (resp_valid),
  .resp_route    (resp_route),
  .resp_filtered (resp_filtered),
  .ecc_start     (ecc_start),
  .ecc_write     (ecc_write)
);

// File: tb/sim_dcache_steer.sv
module sim_dcache_steer;
  logic        clk = 1'b0;
  logic        rst_n, init, cfg_we, cfg_valid, acc_valid, acc_write, fill_valid;
  logic [3:0]  cfg_idx;
  logic [19:0] cfg_addr, acc_addr, fill_addr, ecc_addr;
  logic [31:0] fill_data, resp_data;
  logic        resp_valid, resp_filtered, ecc_start, ecc_write;
  logic [1:0]  resp_route;

  always #2 clk = ~clk;

  dcache_steer u0 (
    .clk(clk), .rst_n(rst_n), .init(init), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .fill_data(fill_data), .resp_valid(resp_valid),
    .resp_route(resp_route), .resp_filtered(resp_filtered), .resp_data(resp_data),
    .ecc_start(ecc_start), .ecc_write(ecc_write), .ecc_addr(ecc_addr)
  );

  typedef struct packed {
    logic [1:0]  rt;
    logic        flt;
    logic [31:0] dat;
    logic        st;
    logic        wr;
    logic [19:0] ad;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  localparam logic [1:0] RN = 2'd0, RC = 2'd1, RE = 2'd2;
  localparam logic [19:0] M0 = 20'h80000, M1 = 20'h80001, M2 = 20'h80002,
                          M3 = 20'h80003, ZQ = 20'h80010;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: offers one access and pushes the expected response
  task automatic drive(input logic wr, input logic [19:0] a, input logic [1:0] rt,
                       input logic flt, input logic [31:0] d, input string tag,
                       input logic fv, input logic [19:0] fa, input logic [31:0] fd);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a;
    fill_valid = fv; fill_addr = fa; fill_data = fd;
    e.rt = rt; e.flt = flt; e.dat = d; e.st = (rt == RE);
    e.wr = wr && (rt == RE); e.ad = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, input logic [1:0] rt, input logic flt,
                    input logic [31:0] d, input string tag);
    drive(1'b0, a, rt, flt, d, tag, 1'b0, '0, '0);
  endtask

  task automatic fill(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic cfg(input logic [3:0] idx, input logic [19:0] a);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_valid = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_init();
    @(negedge clk); init = 1'b1;
    repeat (2) @(negedge clk);
    init = 1'b0;
  endtask

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    exp_t  c;
    string t;
    if (resp_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected response", {31'd0, resp_valid}, 32'd0);
      end else begin
        c = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(resp_route === c.rt, {t, " route"}, {30'd0, resp_route}, {30'd0, c.rt});
        chk(resp_filtered === c.flt, {t, " filtered"}, {31'd0, resp_filtered}, {31'd0, c.flt});
        chk(ecc_start === c.st, {t, " ecc_start"}, {31'd0, ecc_start}, {31'd0, c.st});
        if (c.st) begin
          chk(ecc_write === c.wr, {t, " ecc_write"}, {31'd0, ecc_write}, {31'd0, c.wr});
          chk(ecc_addr === c.ad, {t, " ecc_addr"}, {12'd0, ecc_addr}, {12'd0, c.ad});
        end
        if (c.rt == RC)
          chk(resp_data === c.dat, {t, " data"}, resp_data, c.dat);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; init = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0;
    cfg_addr = '0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
    fill_valid = 1'b0; fill_addr = '0; fill_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(resp_valid === 1'b0, "R1 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
    chk(ecc_start === 1'b0, "R1 ecc_start after reset", {31'd0, ecc_start}, 32'd0);

    // load table during init; an access there gets no response
    init = 1'b1;
    cfg(4'd0, M0); cfg(4'd1, M1); cfg(4'd2, M2); cfg(4'd3, M3);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = M0;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(resp_valid === 1'b0, "R2 no response during init", {31'd0, resp_valid}, 32'd0);
    init = 1'b0;
    @(negedge clk);

    // table write outside init is ignored
    cfg(4'd4, ZQ);
    rd(ZQ, RN, 1'b0, '0, "R3 late table write ignored");
    rd(ZQ, RN, 1'b1, '0, "R4 repeat access filtered");
    rd(20'h00042, RN, 1'b0, '0, "R4 first access unfiltered");

    rd(M0, RE, 1'b0, '0, "R6 multi-defect read miss");
    fill(M0, 32'hA5A5_0000);
    rd(M0, RC, 1'b0, 32'hA5A5_0000, "R7 decoded copy hit");
    drive(1'b1, M0, RE, 1'b0, '0, "R8 write goes to ecc", 1'b0, '0, '0);
    rd(M0, RE, 1'b0, '0, "R8 copy invalidated by write");

    drive(1'b1, M1, RE, 1'b0, '0, "R11 write with same-address fill", 1'b1, M1, 32'h1111_1111);
    rd(M1, RE, 1'b0, '0, "R11 same-cycle fill discarded");
    fill(M1, 32'h2222_2222);
    rd(M1, RC, 1'b0, 32'h2222_2222, "R7 later fill installed");

    pulse_init();
    rd(ZQ, RN, 1'b0, '0, "R10 filter emptied by init");
    rd(M1, RE, 1'b0, '0, "R10 copies emptied by init");

    // filter LRU
    pulse_init();
    for (int k = 0; k < 64; k++)
      rd(20'h00100 + 20'(k), RN, 1'b0, '0, "R5 fill filter");
    rd(20'h00100, RN, 1'b1, '0, "R5 oldest refreshed");
    rd(20'h00200, RN, 1'b0, '0, "R5 new address evicts LRU");
    rd(20'h00100, RN, 1'b1, '0, "R5 refreshed entry kept");
    rd(20'h00101, RN, 1'b0, '0, "R5 second oldest evicted");

    // decoded-copy LRU
    pulse_init();
    fill(M2, 32'hD000_0000);
    fill(M3, 32'hD000_0001);
    for (int k = 2; k < 64; k++)
      fill(20'h90000 + 20'(k), 32'hD000_0000 + 32'(k));
    rd(M2, RC, 1'b0, 32'hD000_0000, "R9 oldest copy refreshed");
    fill(20'h90100, 32'hDEAD_BEEF);
    rd(M3, RE, 1'b0, '0, "R9 second oldest copy evicted");
    rd(M2, RC, 1'b0, 32'hD000_0000, "R9 refreshed copy kept");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 every access answered", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule